// File: doc/BRIEF.md
# Retirement Writeback and Late Branch Redirect

This block is the last stage of an in-order pipeline. Each cycle it may accept one retiring instruction that earlier stages have already decoded and executed. It turns that instruction into architectural effects: register file writes, the release of scoreboard reservations, or a change of control flow. The reservations are held in an external in-order queue that the block cannot see directly.

A retiring instruction that holds a reservation writes its primary result to the reserved register and releases the oldest queue entry. A stack-pop instruction holds two reservations. It writes its secondary value (the adjusted stack pointer) to the register named at the front of the queue and its primary value to its own reserved register, and it releases two entries in the same retirement. A jump-format instruction without a reservation is resolved here, late in the pipeline. A strictly positive target redirects fetch, and a jump-and-link also writes its return address. Every redirect empties the scoreboard and kills all younger in-flight work. All effects appear on registered outputs one clock after the instruction is presented.

Top module: `wb_redirect_unit`

## Requirements
- R1: After reset every output is low or zero: both write enables, the pop count, the clear, the redirect, the squash and the error flag.
- R2: An instruction flagged as no-operation, or carrying the invalid format code 3 (format codes: 0 register, 1 immediate, 2 jump, 3 invalid), retires with no write, no pop, no redirect and no error.
- R3: An instruction holding a reservation, and not a stack pop, drives the next cycle: primary port enabled with address = reserved register and data = result, and pop count = 1.
- R4: A stack pop with a reservation drives the next cycle: pop count = 2; primary port writes the result to the reserved register; secondary port writes the secondary value to the front-of-queue register. The secondary write is dropped when both addresses are equal, so the primary value wins.
- R5: A jump-format instruction without a reservation redirects only when its result, read as a signed number, is greater than zero. The next cycle then shows the redirect valid with pc = result's low PC_W bits, the squash and the scoreboard clear. A result of zero or below has no effect.
- R6: A taken jump-and-link also enables the primary port with address 1 and data = zero-extended pc + 1. A jump-and-link that is not taken writes nothing.
- R7: A retiring slot marked as killed produces no write, no pop, no redirect and no error.
- R8: A write aimed at register 0 keeps its enable low on that port. The scoreboard pop for that instruction still happens.
- R9: If a reservation-holding instruction finds fewer queue entries than it needs (1, or 2 for a pop), the next cycle shows the error flag high, with no writes and a pop count of 0.
- R10: Every effect is a single-cycle pulse. The cycle after an idle input (valid low) shows all outputs idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_valid | input | 1 | A retiring instruction is presented |
| rt_kill | input | 1 | The slot was squashed upstream |
| rt_nop | input | 1 | No-operation instruction |
| rt_fmt | input | 2 | Format code: 0 register, 1 immediate, 2 jump, 3 invalid |
| rt_is_pop | input | 1 | Stack pop (holds two reservations) |
| rt_is_link | input | 1 | Jump-and-link |
| rt_has_rsv | input | 1 | The instruction holds a destination reservation |
| rt_rsv_reg | input | RIDX_W | Reserved destination register |
| rt_result | input | XLEN | Primary result or jump target (-1 when not taken) |
| rt_second | input | XLEN | Secondary value (adjusted stack pointer) |
| rt_pc | input | PC_W | Address of the instruction |
| sb_front_reg | input | RIDX_W | Register held at the front of the scoreboard queue |
| sb_count | input | CNT_W | Number of queued reservations |
| wa_en | output | 1 | Primary write enable |
| wa_addr | output | RIDX_W | Primary write address |
| wa_data | output | XLEN | Primary write data |
| wb_en | output | 1 | Secondary write enable |
| wb_addr | output | RIDX_W | Secondary write address |
| wb_data | output | XLEN | Secondary write data |
| sb_pop | output | 2 | Number of queue entries to release |
| sb_clear | output | 1 | Empty the scoreboard |
| redir_valid | output | 1 | Load the program counter |
| redir_pc | output | PC_W | New program counter |
| squash | output | 1 | Kill all younger in-flight instructions |
| err_underflow | output | 1 | A retirement found too few queue entries |

## Verification
The bench builds the block with 32-bit data, 16 registers, a 16-bit PC and a queue depth of 4. This keeps the queue count small enough to sweep 0, 1 and 2, which covers both underflow thresholds as well as the normal case. The sweep crosses every format code with the kill, no-op, reservation, pop and link flags. It also sweeps targets at -1, 0, 1 and both signed extremes, a PC of all ones so the link address carries out of the PC width, and destination and front-of-queue registers that include register 0 and a collision between the two.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef enum logic [1:0] {
    FMT_REG = 2'd0,
    FMT_IMM = 2'd1,
    FMT_JMP = 2'd2,
    FMT_BAD = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       wr_pri;
    logic       wr_sec;
    logic       link;
    logic       redirect;
    logic       underflow;
    logic [1:0] pops;
  } retire_act_t;

endpackage

// File: rtl/wb_classify.sv
module wb_classify
  import wb_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 3
) (
  input  logic            valid,
  input  logic            kill,
  input  logic            nop,
  input  logic [1:0]      fmt,
  input  logic            is_pop,
  input  logic            is_link,
  input  logic            has_rsv,
  input  logic [XLEN-1:0] result,
  input  logic [CNT_W-1:0] count,
  output logic            active,
  output retire_act_t     act
);

  function automatic logic target_taken(input logic [XLEN-1:0] t);
    return !t[XLEN-1] && (t != '0);
  endfunction

  function automatic logic [1:0] entries_needed(input logic pop);
    return pop ? 2'd2 : 2'd1;
  endfunction

  logic [1:0] need;
  logic       short_q;

  assign active  = valid && !kill && !nop && (fmt_e'(fmt) != FMT_BAD);
  assign need    = entries_needed(is_pop);
  assign short_q = ({{(CNT_W > 2 ? CNT_W-2 : 0){1'b0}}, need} > CNT_W'(count)) ;

  always_comb begin
    act = '0;
    if (active) begin
      if (has_rsv) begin
        if (short_q) begin
          act.underflow = 1'b1;
        end else begin
          act.wr_pri = 1'b1;
          act.wr_sec = is_pop;
          act.pops   = need;
        end
      end else if (fmt_e'(fmt) == FMT_JMP && target_taken(result)) begin
        act.redirect = 1'b1;
        act.link     = is_link;
      end
    end
  end

endmodule

// File: rtl/wb_wport.sv
module wb_wport #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          en,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      en   <= req && (addr_in != '0);
      addr <= req ? addr_in : '0;
      data <= req ? data_in : '0;
    end
  end

endmodule

// File: rtl/wb_redirect_reg.sv
module wb_redirect_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc,
  output logic            squash,
  output logic            sb_clear
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      squash      <= 1'b0;
      sb_clear    <= 1'b0;
    end else begin
      redir_valid <= take;
      redir_pc    <= take ? target : '0;
      squash      <= take;
      sb_clear    <= take;
    end
  end

endmodule

// File: rtl/wb_redirect_unit.sv
module wb_redirect_unit
  import wb_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NREG     = 16,
  parameter int PC_W     = 16,
  parameter int SB_DEPTH = 4,
  parameter int LINK_REG = 1,
  parameter int RIDX_W   = $clog2(NREG),
  parameter int CNT_W    = $clog2(SB_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic              rt_kill,
  input  logic              rt_nop,
  input  logic [1:0]        rt_fmt,
  input  logic              rt_is_pop,
  input  logic              rt_is_link,
  input  logic              rt_has_rsv,
  input  logic [RIDX_W-1:0] rt_rsv_reg,
  input  logic [XLEN-1:0]   rt_result,
  input  logic [XLEN-1:0]   rt_second,
  input  logic [PC_W-1:0]   rt_pc,
  input  logic [RIDX_W-1:0] sb_front_reg,
  input  logic [CNT_W-1:0]  sb_count,
  output logic              wa_en,
  output logic [RIDX_W-1:0] wa_addr,
  output logic [XLEN-1:0]   wa_data,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_addr,
  output logic [XLEN-1:0]   wb_data,
  output logic [1:0]        sb_pop,
  output logic              sb_clear,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc,
  output logic              squash,
  output logic              err_underflow
);

  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  function automatic logic [XLEN-1:0] return_addr(input logic [PC_W-1:0] pc);
    return XLEN'(pc) + XLEN'(1);
  endfunction

  retire_act_t act;
  logic        ev_active;
  logic        ev_redirect;
  logic        ev_underflow;
  logic        pri_req;
  logic        sec_req;
  logic [RIDX_W-1:0] pri_addr;
  logic [XLEN-1:0]   pri_data;

  wb_classify #(.XLEN(XLEN), .CNT_W(CNT_W)) u_cls (
    .valid   (rt_valid),
    .kill    (rt_kill),
    .nop     (rt_nop),
    .fmt     (rt_fmt),
    .is_pop  (rt_is_pop),
    .is_link (rt_is_link),
    .has_rsv (rt_has_rsv),
    .result  (rt_result),
    .count   (sb_count),
    .active  (ev_active),
    .act     (act)
  );

  assign ev_redirect  = act.redirect;
  assign ev_underflow = act.underflow;
  assign pri_req  = act.wr_pri || act.link;
  assign pri_addr = act.link ? LINK_IDX : rt_rsv_reg;
  assign pri_data = act.link ? return_addr(rt_pc) : rt_result;
  assign sec_req  = act.wr_sec && (sb_front_reg != rt_rsv_reg);

  wb_wport #(.AW(RIDX_W), .DW(XLEN)) u_port_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pri_req),
    .addr_in (pri_addr),
    .data_in (pri_data),
    .en      (wa_en),
    .addr    (wa_addr),
    .data    (wa_data)
  );

  wb_wport #(.AW(RIDX_W), .DW(XLEN)) u_port_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (sec_req),
    .addr_in (sb_front_reg),
    .data_in (rt_second),
    .en      (wb_en),
    .addr    (wb_addr),
    .data    (wb_data)
  );

  wb_redirect_reg #(.PC_W(PC_W)) u_redir (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (ev_redirect),
    .target      (rt_result[PC_W-1:0]),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .squash      (squash),
    .sb_clear    (sb_clear)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_pop        <= 2'd0;
      err_underflow <= 1'b0;
    end else begin
      sb_pop        <= act.pops;
      err_underflow <= ev_underflow;
    end
  end

endmodule

// File: rtl/wb_redirect_unit_chk.sv
module wb_redirect_unit_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rt_valid,
  input logic              rt_kill,
  input logic              rt_nop,
  input logic [1:0]        rt_fmt,
  input logic              rt_has_rsv,
  input logic [XLEN-1:0]   rt_result,
  input logic              ev_active,
  input logic              ev_redirect,
  input logic              wa_en,
  input logic [RIDX_W-1:0] wa_addr,
  input logic              wb_en,
  input logic [RIDX_W-1:0] wb_addr,
  input logic [1:0]        sb_pop,
  input logic              sb_clear,
  input logic              redir_valid,
  input logic              squash,
  input logic              err_underflow
);

  assert_idle_on_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && (rt_nop || rt_fmt == 2'd3)) |=>
      (!wa_en && !wb_en && sb_pop == 2'd0 && !redir_valid && !err_underflow));

  assert_taken_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && !rt_kill && !rt_nop && rt_fmt == 2'd2 && !rt_has_rsv &&
     !rt_result[XLEN-1] && rt_result != '0) |=> (redir_valid && squash && sb_clear));

  assert_redirect_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(ev_redirect));

  assert_squash_with_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (sb_clear && redir_valid && sb_pop == 2'd0 && !wb_en));

  assert_killed_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_kill) |=>
      (!wa_en && !wb_en && sb_pop == 2'd0 && !redir_valid && !err_underflow));

  assert_no_reg0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en |-> wa_addr != '0) and (wb_en |-> wb_addr != '0));

  assert_underflow_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> (!wa_en && !wb_en && sb_pop == 2'd0 && !redir_valid));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_active |=> (!wa_en && !wb_en && sb_pop == 2'd0 && !squash && !err_underflow));

  assert_pop_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sb_pop != 2'd3);

endmodule

bind wb_redirect_unit wb_redirect_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rt_valid      (rt_valid),
  .rt_kill       (rt_kill),
  .rt_nop        (rt_nop),
  .rt_fmt        (rt_fmt),
  .rt_has_rsv    (rt_has_rsv),
  .rt_result     (rt_result),
  .ev_active     (ev_active),
  .ev_redirect   (ev_redirect),
  .wa_en         (wa_en),
  .wa_addr       (wa_addr),
  .wb_en         (wb_en),
  .wb_addr       (wb_addr),
  .sb_pop        (sb_pop),
  .sb_clear      (sb_clear),
  .redir_valid   (redir_valid),
  .squash        (squash),
  .err_underflow (err_underflow)
);

// File: tb/wb_redirect_unit_tb.sv
module wb_redirect_unit_tb;

  localparam int XLEN = 32;
  localparam int NREG = 16;
  localparam int PC_W = 16;
  localparam int SB_DEPTH = 4;
  localparam int RIDX_W = 4;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rt_valid = 0, rt_kill = 0, rt_nop = 0, rt_is_pop = 0, rt_is_link = 0, rt_has_rsv = 0;
  logic [1:0] rt_fmt = 0;
  logic [RIDX_W-1:0] rt_rsv_reg = 0, sb_front_reg = 0;
  logic [XLEN-1:0] rt_result = 0, rt_second = 0;
  logic [PC_W-1:0] rt_pc = 0;
  logic [CNT_W-1:0] sb_count = 0;
  logic wa_en, wb_en, sb_clear, redir_valid, squash, err_underflow;
  logic [RIDX_W-1:0] wa_addr, wb_addr;
  logic [XLEN-1:0] wa_data, wb_data;
  logic [1:0] sb_pop;
  logic [PC_W-1:0] redir_pc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wb_redirect_unit #(.XLEN(XLEN), .NREG(NREG), .PC_W(PC_W), .SB_DEPTH(SB_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_kill(rt_kill), .rt_nop(rt_nop),
    .rt_fmt(rt_fmt), .rt_is_pop(rt_is_pop), .rt_is_link(rt_is_link), .rt_has_rsv(rt_has_rsv),
    .rt_rsv_reg(rt_rsv_reg), .rt_result(rt_result), .rt_second(rt_second), .rt_pc(rt_pc),
    .sb_front_reg(sb_front_reg), .sb_count(sb_count),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .sb_pop(sb_pop), .sb_clear(sb_clear), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .squash(squash), .err_underflow(err_underflow)
  );

  logic e_aen, e_ben, e_redir, e_err;
  logic [RIDX_W-1:0] e_aaddr, e_baddr;
  logic [XLEN-1:0] e_adata, e_bdata;
  logic [1:0] e_pop;
  logic [PC_W-1:0] e_pc;

  task automatic set_idle_expect();
    e_aen = 0; e_ben = 0; e_redir = 0; e_err = 0; e_pop = 0;
    e_aaddr = 0; e_baddr = 0; e_adata = 0; e_bdata = 0; e_pc = 0;
  endtask

  task automatic compare(input string tag);
    bit bad;
    bad = (wa_en !== e_aen) || (wb_en !== e_ben) || (sb_pop !== e_pop) ||
          (redir_valid !== e_redir) || (squash !== e_redir) || (sb_clear !== e_redir) ||
          (err_underflow !== e_err) ||
          (e_aen && (wa_addr !== e_aaddr || wa_data !== e_adata)) ||
          (e_ben && (wb_addr !== e_baddr || wb_data !== e_bdata)) ||
          (e_redir && redir_pc !== e_pc);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: actual a=%b/%0d/%h b=%b/%0d/%h pop=%0d rd=%b/%b/%b pc=%h err=%b expected a=%b/%0d/%h b=%b/%0d/%h pop=%0d rd=%b pc=%h err=%b",
               tag, wa_en, wa_addr, wa_data, wb_en, wb_addr, wb_data, sb_pop,
               redir_valid, squash, sb_clear, redir_pc, err_underflow,
               e_aen, e_aaddr, e_adata, e_ben, e_baddr, e_bdata, e_pop, e_redir, e_pc, e_err);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run unfinished expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [XLEN-1:0] results [6];
    logic [RIDX_W-1:0] rsvs [2];
    logic [RIDX_W-1:0] fronts [3];
    string tag;
    logic act;
    logic [1:0] need;
    results[0] = 32'hffff_ffff; results[1] = 32'h0; results[2] = 32'h1;
    results[3] = 32'h0001_1234; results[4] = 32'h7fff_ffff; results[5] = 32'h8000_0000;
    rsvs[0] = 4'd0; rsvs[1] = 4'd3;
    fronts[0] = 4'd0; fronts[1] = 4'd3; fronts[2] = 4'd5;

    repeat (3) @(negedge clk);
    set_idle_expect();
    compare("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 idle after reset");

    for (int f = 0; f < 4; f++)
    for (int flags = 0; flags < 32; flags++)
    for (int ri = 0; ri < 6; ri++)
    for (int c = 0; c < 3; c++)
    for (int rv = 0; rv < 2; rv++)
    for (int fr = 0; fr < 3; fr++) begin
      rt_valid   = 1'b1;
      rt_fmt     = 2'(f);
      rt_kill    = flags[0];
      rt_nop     = flags[1];
      rt_has_rsv = flags[2];
      rt_is_pop  = flags[3];
      rt_is_link = flags[4];
      rt_result  = results[ri];
      rt_second  = ~results[ri] ^ XLEN'(fr);
      rt_pc      = (ri == 4) ? 16'hffff : PC_W'(16'h0100 + ri * 7 + c);
      sb_count   = CNT_W'(c);
      rt_rsv_reg = rsvs[rv];
      sb_front_reg = fronts[fr];

      set_idle_expect();
      act = !rt_kill && !rt_nop && (f != 3);
      if (rt_kill) tag = "R7 killed slot";
      else if (!act) tag = "R2 nop or invalid";
      else tag = "R5 jump resolve";
      if (act && rt_has_rsv) begin
        need = rt_is_pop ? 2'd2 : 2'd1;
        if (c < int'(need)) begin
          e_err = 1; tag = "R9 underflow";
        end else begin
          e_pop = need;
          e_aen = (rt_rsv_reg != 0); e_aaddr = rt_rsv_reg; e_adata = rt_result;
          if (rt_is_pop) begin
            e_ben = (sb_front_reg != 0) && (sb_front_reg != rt_rsv_reg);
            e_baddr = sb_front_reg; e_bdata = rt_second;
            tag = "R4 pop double write";
          end else if (rt_rsv_reg == 0) tag = "R8 reg0 suppressed";
          else tag = "R3 reserved write";
        end
      end else if (act && f == 2 && $signed(rt_result) > 0) begin
        e_redir = 1; e_pc = rt_result[PC_W-1:0];
        if (rt_is_link) begin
          e_aen = 1; e_aaddr = 4'd1; e_adata = {16'h0, rt_pc} + 32'd1;
          tag = "R6 link write";
        end
      end else if (act && rt_is_link) tag = "R6 link not taken";

      @(negedge clk);
      rt_valid = 1'b0;
      compare(tag);
      set_idle_expect();
      @(negedge clk);
      compare("R10 single pulse");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule